// File: doc/BRIEF.md
# Two-Wire Bus Start/Stop Monitor

This block listens to the clock and data lines of a shared two-wire bus (I2C style) and tells a local controller whether the bus is busy. Both lines first pass through a configurable synchroniser. The block then detects Start and Stop conditions by comparing each sampled level with the one before it. It keeps two status flags that exclude each other: one for "last condition seen was a Start" and one for "last condition seen was a Stop". From these flags it derives a bus-free indication. The controller may claim the bus only while that indication is high.

A sticky interrupt flag is set by Start conditions, by Stop conditions and by a byte-complete strobe from an attached shifter. Only an explicit clear strobe removes it. A separate interrupt enable gates the interrupt output and leaves the flag alone. If the interrupt is enabled while the bus is busy, the block arms itself to wait for the Stop that frees the bus. Until that Stop, Starts and byte strobes do not raise the flag.

Top module: `i2c_bus_monitor`

## Requirements
- R1: After reset, and on the clock edge after `enable` is sampled low, `start_seen`, `stop_seen` and the internal stop-wait state are all 0. After reset `irq_flag` is 0.
- R2: A Start is the data line falling while the clock line stays high. While enabled, it sets `start_seen` to 1 and clears `stop_seen`. The change is visible after the third rising clock edge that follows the line change: two synchroniser stages, then the flag register.
- R3: A Stop is the data line rising while the clock line stays high. While enabled, it sets `stop_seen` and clears `start_seen`, with the same latency as R2.
- R4: Changes of the data line while the clock line is low, and changes of the clock line itself, leave `start_seen` and `stop_seen` unchanged.
- R5: `bus_free` is 1 when `stop_seen` is 1, or when both flags are 0. It is 0 when `start_seen` is 1.
- R6: While enabled and not waiting for a Stop, a Start, a Stop or a one-cycle `byte_done` pulse sets `irq_flag`. The `byte_done` case takes effect on the next rising edge.
- R7: `irq_flag` stays at 1 until `flag_clr` is sampled high. If a set event and `flag_clr` fall in the same cycle, the flag ends up at 1.
- R8: `irq_out` equals `irq_flag` AND `irq_en`. Changing `irq_en` never changes `irq_flag`.
- R9: If `irq_en` rises while `start_seen` is 1, the block waits for a Stop. Until the next Stop, Starts and `byte_done` do not set `irq_flag`. That Stop sets `irq_flag` and ends the wait.
- R10: While `enable` is 0, bus conditions and `byte_done` neither set flags nor set `irq_flag`. `flag_clr` still clears `irq_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Monitor enable; low clears the bus flags |
| scl_in | input | 1 | Raw bus clock line level |
| sda_in | input | 1 | Raw bus data line level |
| byte_done | input | 1 | One-cycle strobe from the shifter on byte completion |
| flag_clr | input | 1 | Clears the interrupt flag |
| irq_en | input | 1 | Interrupt output enable, also arms the stop-wait |
| start_seen | output | 1 | Last bus condition was a Start |
| stop_seen | output | 1 | Last bus condition was a Stop |
| bus_free | output | 1 | Bus may be claimed |
| irq_flag | output | 1 | Sticky interrupt flag |
| irq_out | output | 1 | Gated interrupt request |

## Verification
A line change reaches the Start/Stop flags, and through them `bus_free` and `irq_flag`, three rising edges after it is driven. A `byte_done`, `flag_clr` or `enable` change acts on the first rising edge. A change of `irq_en` reaches `irq_out` at once. The bench drives every input on a falling edge and holds it for at least four rising edges. It samples on a falling edge only after that, so each result has already settled when it is compared with the bench's own model.

// File: rtl/i2cmon_pkg.sv
// Shared types for the two-wire bus monitor.
package i2cmon_pkg;
    // Bus condition pulses, one cycle wide each
    typedef struct packed {
        logic start;
        logic stop;
    } bus_evt_t;
endpackage

// File: rtl/i2cmon_sync.sv
// Multi-stage level synchroniser for one asynchronous bus line.
// Assumes the line idles high, so every stage resets to 1.
module i2cmon_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // Shift the raw level through the register chain
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/i2cmon_cond_detect.sv
// Detects Start and Stop conditions on synchronised bus levels.
// Assumes both inputs are already synchronous to clk. The clock line
// must be high in the previous and the current sample for a condition.
module i2cmon_cond_detect
    import i2cmon_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     scl_s,
    input  logic     sda_s,
    output bus_evt_t evt
);
    logic scl_prev;
    logic sda_prev;
    logic scl_high;

    // Remember the previous sample of both lines
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_prev <= scl_s;
            sda_prev <= sda_s;
        end
    end

    // Classify a data edge during a steady high clock
    always_comb begin
        scl_high  = scl_s & scl_prev;
        evt.start = scl_high & sda_prev & ~sda_s;
        evt.stop  = scl_high & ~sda_prev & sda_s;
    end
endmodule

// File: rtl/i2cmon_flags.sv
// Start/Stop status flags that exclude each other, cleared while disabled.
module i2cmon_flags
    import i2cmon_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     enable,
    input  bus_evt_t evt,
    output logic     s_flag,
    output logic     p_flag
);
    // Update the flags from the latest bus condition
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            s_flag <= 1'b0;
            p_flag <= 1'b0;
        end else if (evt.start) begin
            s_flag <= 1'b1;
            p_flag <= 1'b0;
        end else if (evt.stop) begin
            s_flag <= 1'b0;
            p_flag <= 1'b1;
        end
    end
endmodule

// File: rtl/i2cmon_irq.sv
// Sticky interrupt flag with a stop-wait mode.
// Assumes byte_done is a one-cycle strobe. A set event wins over the clear.
module i2cmon_irq
    import i2cmon_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     enable,
    input  bus_evt_t evt,
    input  logic     byte_done,
    input  logic     flag_clr,
    input  logic     irq_en,
    input  logic     bus_busy,
    output logic     irq_flag,
    output logic     armed
);
    logic irq_en_q;
    logic set_evt;

    // Decide whether this cycle raises the flag
    always_comb begin
        set_evt = enable & (evt.stop | (~armed & (evt.start | byte_done)));
    end

    // Hold the enable history and the stop-wait state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_en_q <= 1'b0;
            armed    <= 1'b0;
        end else begin
            irq_en_q <= irq_en;
            if (!enable || evt.stop)
                armed <= 1'b0;
            else if (irq_en && !irq_en_q && bus_busy)
                armed <= 1'b1;
        end
    end

    // Sticky flag: set has priority over clear
    always_ff @(posedge clk) begin
        if (!rst_n)        irq_flag <= 1'b0;
        else if (set_evt)  irq_flag <= 1'b1;
        else if (flag_clr) irq_flag <= 1'b0;
    end
endmodule

// File: rtl/i2c_bus_monitor.sv
// Top of the two-wire bus monitor: synchronisers, condition detector,
// status flags and interrupt logic. Assumes raw lines may be asynchronous.
module i2c_bus_monitor
    import i2cmon_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic scl_in,
    input  logic sda_in,
    input  logic byte_done,
    input  logic flag_clr,
    input  logic irq_en,
    output logic start_seen,
    output logic stop_seen,
    output logic bus_free,
    output logic irq_flag,
    output logic irq_out
);
    localparam int LINES = 2;

    logic [LINES-1:0] raw_lines;
    logic [LINES-1:0] sync_lines;
    bus_evt_t         evt;
    logic             evt_stop;
    logic             armed;

    assign raw_lines = {scl_in, sda_in};

    // One synchroniser per bus line
    for (genvar i = 0; i < LINES; i++) begin : g_sync
        i2cmon_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .d     (raw_lines[i]),
            .q     (sync_lines[i])
        );
    end

    i2cmon_cond_detect u_det (
        .clk   (clk),
        .rst_n (rst_n),
        .scl_s (sync_lines[1]),
        .sda_s (sync_lines[0]),
        .evt   (evt)
    );

    i2cmon_flags u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (enable),
        .evt    (evt),
        .s_flag (start_seen),
        .p_flag (stop_seen)
    );

    i2cmon_irq u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .evt       (evt),
        .byte_done (byte_done),
        .flag_clr  (flag_clr),
        .irq_en    (irq_en),
        .bus_busy  (start_seen),
        .irq_flag  (irq_flag),
        .armed     (armed)
    );

    // Derive the free indication and the gated interrupt
    always_comb begin
        evt_stop = evt.stop;
        bus_free = stop_seen | (~start_seen & ~stop_seen);
        irq_out  = irq_flag & irq_en;
    end
endmodule

// File: rtl/i2cmon_checker.sv
// Property checker for the bus monitor, attached by bind.
module i2cmon_checker (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic byte_done,
    input logic flag_clr,
    input logic irq_en,
    input logic start_seen,
    input logic stop_seen,
    input logic bus_free,
    input logic irq_flag,
    input logic irq_out,
    input logic armed,
    input logic evt_stop
);
    a_r2_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_seen && stop_seen));

    a_r1_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!start_seen && !stop_seen && !armed));

    a_r5_busy_not_free: assert property (@(posedge clk) disable iff (!rst_n)
        start_seen |-> !bus_free);

    a_r5_stop_free: assert property (@(posedge clk) disable iff (!rst_n)
        stop_seen |-> bus_free);

    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flag && !flag_clr) |=> irq_flag);

    a_r6_byte_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && byte_done && !armed) |=> irq_flag);

    a_r9_stop_ends_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && armed && evt_stop) |=> (irq_flag && !armed));

    a_r8_gate_off: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq_out);

    a_r10_disabled_no_set: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && !irq_flag) |=> !irq_flag);
endmodule

bind i2c_bus_monitor i2cmon_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .byte_done  (byte_done),
    .flag_clr   (flag_clr),
    .irq_en     (irq_en),
    .start_seen (start_seen),
    .stop_seen  (stop_seen),
    .bus_free   (bus_free),
    .irq_flag   (irq_flag),
    .irq_out    (irq_out),
    .armed      (armed),
    .evt_stop   (evt_stop)
);

// File: tb/i2c_bus_monitor_bench.sv
// Self-checking bench: random operation mix plus directed corner cases.
module i2c_bus_monitor_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0;
    logic scl_in = 1'b1;
    logic sda_in = 1'b1;
    logic byte_done = 1'b0;
    logic flag_clr = 1'b0;
    logic irq_en = 1'b0;
    logic start_seen, stop_seen, bus_free, irq_flag, irq_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // bench model state
    bit m_s, m_p, m_irq, m_armed;

    always #2.5 clk = ~clk;

    i2c_bus_monitor u_i2c_bus_monitor (
        .clk(clk), .rst_n(rst_n), .enable(enable), .scl_in(scl_in),
        .sda_in(sda_in), .byte_done(byte_done), .flag_clr(flag_clr),
        .irq_en(irq_en), .start_seen(start_seen), .stop_seen(stop_seen),
        .bus_free(bus_free), .irq_flag(irq_flag), .irq_out(irq_out)
    );

    function automatic bit exp_free(bit s, bit p);
        return p | (!s & !p);
    endfunction

    task automatic check(string req, bit act, bit exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_all(string tag);
        check({tag, " R2 start_seen"}, start_seen, m_s);
        check({tag, " R3 stop_seen"}, stop_seen, m_p);
        check({tag, " R5 bus_free"}, bus_free, exp_free(m_s, m_p));
        check({tag, " R7 irq_flag"}, irq_flag, m_irq);
        check({tag, " R8 irq_out"}, irq_out, m_irq & irq_en);
    endtask

    task automatic settle();
        repeat (4) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic lines(bit c, bit d);
        scl_in = c; sda_in = d;
        settle();
    endtask

    task automatic do_start();
        lines(1'b0, sda_in); lines(1'b0, 1'b1); lines(1'b1, 1'b1);
        check_all("R4 pre-start");
        lines(1'b1, 1'b0);
        if (enable) begin m_s = 1; m_p = 0; if (!m_armed) m_irq = 1; end
        check_all("R2 start");
    endtask

    task automatic do_stop();
        lines(1'b0, sda_in); lines(1'b0, 1'b0); lines(1'b1, 1'b0);
        check_all("R4 pre-stop");
        lines(1'b1, 1'b1);
        if (enable) begin m_s = 0; m_p = 1; m_irq = 1; m_armed = 0; end
        check_all("R3 stop");
    endtask

    task automatic do_bit(bit d);
        lines(1'b0, sda_in); lines(1'b0, d); lines(1'b1, d); lines(1'b0, d);
        check_all("R4 data bit");
    endtask

    task automatic pulse(bit bd, bit clr);
        byte_done = bd; flag_clr = clr;
        @(negedge clk);
        byte_done = 0; flag_clr = 0;
        if (bd && enable && !m_armed) m_irq = 1;
        else if (clr) m_irq = 0;
        settle();
        check_all(bd ? (clr ? "R7 set wins" : "R6 byte") : "R7 clear");
    endtask

    task automatic set_irq_en(bit v);
        if (v && !irq_en && enable && m_s) m_armed = 1;
        irq_en = v;
        settle();
        check_all("R8 irq_en");
    endtask

    task automatic set_enable(bit v);
        enable = v;
        if (!v) begin m_s = 0; m_p = 0; m_armed = 0; end
        settle();
        check_all(v ? "R1 enable" : "R1 disable");
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1c2b));
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_all("R1 reset");
        rst_n = 1;
        settle();
        check_all("R1 after reset");
        // directed: disabled ignores conditions and bytes (R10)
        do_start(); pulse(1, 0);
        check("R10 disabled irq", irq_flag, 1'b0);
        set_enable(1);
        do_start(); do_bit(1); do_bit(0); pulse(1, 0);
        pulse(0, 1); pulse(1, 1);
        do_stop();
        // directed: stop-wait arming (R9)
        pulse(0, 1); do_start(); pulse(0, 1);
        set_irq_en(1);
        pulse(1, 0);
        check("R9 byte masked", irq_flag, 1'b0);
        do_start();
        check("R9 start masked", irq_flag, 1'b0);
        do_stop();
        check("R9 stop fires", irq_out, 1'b1);
        set_irq_en(0);
        check("R8 flag kept", irq_flag, 1'b1);
        do_start(); set_enable(0);
        check("R1 disable free", bus_free, 1'b1);
        set_enable(1);
        // random mix
        for (int i = 0; i < 400; i++) begin
            case ($urandom_range(0, 7))
                0: do_start();
                1: do_stop();
                2: do_bit(1'($urandom_range(0, 1)));
                3: pulse(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
                4: set_irq_en(1'($urandom_range(0, 1)));
                5: set_enable($urandom_range(0, 3) != 0);
                6: do_start();
                default: pulse(1, 0);
            endcase
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule